// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one read or write burst on a 256-column SDRAM page. A start strobe captures the starting column, the burst length code, the burst type and the access direction. From the next clock on, the block presents one column per cycle, together with a valid flag and a last-beat flag. When a bounded burst reaches the edge of its aligned block, it wraps inside that block. Interleaved bursts visit the block's columns in XOR order. A full-page burst walks the whole row, wraps around, and keeps running until a terminate arrives.

An advance enable freezes the sequence for as many cycles as the surrounding controller needs, for example during a clock-suspend stall. A new start strobe that arrives while a burst is running abandons that burst and restarts from the new column, which lets a following command interrupt the current one. A length code that names no legal length, and a full-page request combined with interleaved order, each run as a single-beat access and raise an error flag.

Top module: `burst_colgen`

## Requirements
- R1: Length code `len_code_i` selects the burst length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The cycle after an edge with `start_i` high, `col_valid_o` is 1 and `col_o` equals the captured `start_col_i`.
- R2: With `ilv_i`=0 (sequential order) and length L of 2, 4 or 8, the low log2(L) bits of beat k equal (start low bits + k) mod L. All higher column bits stay equal to those of the start column.
- R3: With `ilv_i`=1 (interleaved order) and length L of 2, 4 or 8, the low log2(L) bits of beat k equal the start low bits XOR k. The higher bits stay fixed.
- R4: In full-page mode, each advance adds one to the column and wraps from 255 to 0. The burst continues until `stop_i`, and `last_o` is never 1.
- R5: At length 1, exactly one beat is produced at the start column, whatever the value of `ilv_i`.
- R6: When `is_write_i`=1 and `wr_single_i`=1 at start, the burst is one beat long, whatever the length code. Reads are not affected by `wr_single_i`.
- R7: `last_o` is 1 exactly on the final beat of a bounded burst. If `adv_i` is high at that beat, `col_valid_o` is 0 in the next cycle.
- R8: While `adv_i` is 0 during a burst (with no start and no stop), `col_o` and the beat position hold and `col_valid_o` stays 1.
- R9: `stop_i` high at an edge during a burst (with no start) makes `col_valid_o` 0 in the next cycle.
- R10: `start_i` high during an active burst discards it, and the new sequence begins from the new start column in the next cycle.
- R11: The codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with `ilv_i`=1, run as a length-1 burst and set `rsv_err_o`. The flag holds its value until the next start.
- R12: During reset, `col_valid_o`, `last_o` and `rsv_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_code_i | input | 3 | Burst length code, sampled at start |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential, sampled at start |
| wr_single_i | input | 1 | 1 = writes are single-beat, sampled at start |
| is_write_i | input | 1 | 1 = burst is a write, sampled at start |
| start_i | input | 1 | Begin a burst (restarts any burst in progress) |
| start_col_i | input | 8 | Starting column |
| stop_i | input | 1 | Terminate the running burst |
| adv_i | input | 1 | Advance enable; 0 holds the current beat |
| col_o | output | 8 | Current column address |
| col_valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | Current beat is the final one of a bounded burst |
| rsv_err_o | output | 1 | Last start used an illegal length/type setting |

## Verification
The hardest cases to reach from the ports are those where two controls act on the same beat. One is a stall on a block-wrap beat. Another is a restart that lands while a previous burst is still mid-block. A third is a full-page walk that crosses column 255 without flagging a last beat. The stimulus reaches them in three ways. It starts bursts near the top of an aligned block or near the top of the row. It applies hold patterns in the advance enable that cover the wrap beat. It issues a new start a fixed number of cycles into a running burst, so the interrupted and the new sequence sit back to back in the expected-item queue.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    parameter int COL_W  = 8;
    parameter int BEAT_W = 3;
    parameter int LOG_W  = $clog2(BEAT_W + 1);

    localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

    typedef struct packed {
        logic              active;
        logic              full;
        logic              ilv;
        logic              err;
        logic [LOG_W-1:0]  len_log;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] org;
        logic [COL_W-1:0]  col;
    } gen_st_t;

    // Low-bit mask of a block of 2**lg columns.
    function automatic logic [BEAT_W-1:0] len_mask(input logic [LOG_W-1:0] lg);
        logic [BEAT_W-1:0] m;
        for (int i = 0; i < BEAT_W; i++) begin
            m[i] = (i < int'(lg));
        end
        return m;
    endfunction

endpackage

// File: rtl/bcg_mode_dec.sv
module bcg_mode_dec
    import bcg_pkg::*;
(
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             is_write_i,
    input  logic             wr_single_i,
    output logic [LOG_W-1:0] len_log_o,
    output logic             full_o,
    output logic             err_o
);

    always_comb begin
        len_log_o = '0;
        full_o    = 1'b0;
        err_o     = 1'b0;
        if (len_code_i == LEN_CODE_PAGE) begin
            if (ilv_i) err_o  = 1'b1;
            else       full_o = 1'b1;
        end else if (int'(len_code_i) <= BEAT_W) begin
            len_log_o = len_code_i[LOG_W-1:0];
        end else begin
            err_o = 1'b1;
        end
        // single-location writes override the programmed length
        if (is_write_i && wr_single_i) begin
            len_log_o = '0;
            full_o    = 1'b0;
        end
    end

endmodule

// File: rtl/bcg_next_col.sv
module bcg_next_col
    import bcg_pkg::*;
(
    input  logic [COL_W-1:0]  col_i,
    input  logic [BEAT_W-1:0] org_i,
    input  logic [BEAT_W-1:0] beat_n_i,
    input  logic [LOG_W-1:0]  len_log_i,
    input  logic              ilv_i,
    input  logic              full_i,
    output logic [COL_W-1:0]  col_o
);

    localparam int PAD_W = COL_W - BEAT_W;

    logic [BEAT_W-1:0] mask;
    logic [BEAT_W-1:0] low_seq;
    logic [BEAT_W-1:0] low_ilv;
    logic [BEAT_W-1:0] low;
    logic [COL_W-1:0]  mask_w;

    always_comb begin
        mask    = len_mask(len_log_i);
        low_seq = org_i + beat_n_i;
        low_ilv = org_i ^ beat_n_i;
        low     = ilv_i ? low_ilv : low_seq;
        mask_w  = {{PAD_W{1'b0}}, mask};
        if (full_i) begin
            col_o = col_i + 1'b1;
        end else begin
            col_o = (col_i & ~mask_w) | ({{PAD_W{1'b0}}, low} & mask_w);
        end
    end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import bcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             wr_single_i,
    input  logic             is_write_i,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             stop_i,
    input  logic             adv_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_valid_o,
    output logic             last_o,
    output logic             rsv_err_o
);

    gen_st_t st_d, st_q;

    logic [LOG_W-1:0] dec_log;
    logic             dec_full;
    logic             dec_err;
    logic [COL_W-1:0] col_step;
    logic [BEAT_W-1:0] beat_n;
    logic             last_c;

    bcg_mode_dec u_dec (
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .is_write_i  (is_write_i),
        .wr_single_i (wr_single_i),
        .len_log_o   (dec_log),
        .full_o      (dec_full),
        .err_o       (dec_err)
    );

    assign beat_n = st_q.beat + 1'b1;

    bcg_next_col u_step (
        .col_i     (st_q.col),
        .org_i     (st_q.org),
        .beat_n_i  (beat_n),
        .len_log_i (st_q.len_log),
        .ilv_i     (st_q.ilv),
        .full_i    (st_q.full),
        .col_o     (col_step)
    );

    always_comb begin
        st_d   = st_q;
        last_c = st_q.active && !st_q.full && (st_q.beat == len_mask(st_q.len_log));
        if (start_i) begin
            st_d.active  = 1'b1;
            st_d.full    = dec_full;
            st_d.ilv     = ilv_i;
            st_d.err     = dec_err;
            st_d.len_log = dec_log;
            st_d.beat    = '0;
            st_d.org     = start_col_i[BEAT_W-1:0];
            st_d.col     = start_col_i;
        end else if (st_q.active) begin
            if (stop_i) begin
                st_d.active = 1'b0;
            end else if (adv_i) begin
                if (last_c) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.beat = beat_n;
                    st_d.col  = col_step;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_o       = st_q.col;
    assign col_valid_o = st_q.active;
    assign last_o      = last_c;
    assign rsv_err_o   = st_q.err;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk
    import bcg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       len_code_i,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic             adv_i,
    input logic [COL_W-1:0] col_o,
    input logic             col_valid_o,
    input logic             last_o,
    input logic             rsv_err_o,
    input logic             full_i
);

    assert_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> col_valid_o && (col_o == $past(start_col_i)));

    // R2 / R3: bits above the largest block never change inside a bounded burst
    assert_upper_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o && adv_i && !start_i && !stop_i && !last_o && !full_i
        |=> col_o[COL_W-1:BEAT_W] == $past(col_o[COL_W-1:BEAT_W]));

    assert_page_no_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o && full_i |-> !last_o);

    assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o && last_o && adv_i && !start_i |=> !col_valid_o);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o && !adv_i && !start_i && !stop_i |=> col_valid_o && $stable(col_o));

    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o && stop_i && !start_i |=> !col_valid_o);

    assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && len_code_i[2] && (len_code_i != 3'b111)
        |=> rsv_err_o && last_o && col_valid_o);

endmodule

bind burst_colgen burst_colgen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .len_code_i  (len_code_i),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .adv_i       (adv_i),
    .col_o       (col_o),
    .col_valid_o (col_valid_o),
    .last_o      (last_o),
    .rsv_err_o   (rsv_err_o),
    .full_i      (st_q.full)
);

// File: tb/burst_colgen_test.sv
`timescale 1ns/1ps
module burst_colgen_test;

    typedef struct {
        logic [7:0] col;
        logic       last;
        logic       err;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       wr_single_i = 1'b0;
    logic       is_write_i = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic       stop_i = 1'b0;
    logic       adv_i = 1'b1;
    logic [7:0] col_o;
    logic       col_valid_o;
    logic       last_o;
    logic       rsv_err_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done_flag = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .len_code_i(len_code_i), .ilv_i(ilv_i),
        .wr_single_i(wr_single_i), .is_write_i(is_write_i), .start_i(start_i),
        .start_col_i(start_col_i), .stop_i(stop_i), .adv_i(adv_i),
        .col_o(col_o), .col_valid_o(col_valid_o), .last_o(last_o), .rsv_err_o(rsv_err_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] exp_col(logic [7:0] s, int len, bit full, bit ilv, int k);
        logic [7:0] m;
        logic [7:0] lo;
        if (full) return 8'((int'(s) + k) % 256);
        m  = 8'(len - 1);
        lo = ilv ? ((s & m) ^ 8'(k)) : 8'((int'(s & m) + k) % len);
        return (s & ~m) | (lo & m);
    endfunction

    // Drives one burst from a negedge; returns at a negedge.
    task automatic burst(string tag, logic [2:0] code, logic ilv, logic wr, logic ws,
                         logic [7:0] scol, int hold_mask, int stop_at, int cut_at);
        int   len = 1;
        bit   full = 0;
        bit   err = 0;
        int   k = 0;
        bit   done = 0;
        exp_t e;
        case (code)
            3'b000: len = 1;
            3'b001: len = 2;
            3'b010: len = 4;
            3'b011: len = 8;
            3'b111: if (ilv) err = 1; else full = 1;
            default: err = 1;
        endcase
        if (wr && ws) begin len = 1; full = 0; end
        len_code_i = code; ilv_i = ilv; is_write_i = wr; wr_single_i = ws;
        start_col_i = scol; start_i = 1'b1; stop_i = 1'b0; adv_i = 1'b1;
        e.col = exp_col(scol, len, full, ilv, 0); e.last = !full && (len == 1);
        e.err = err; e.tag = tag; q.push_back(e);
        for (int cyc = 0; !done; cyc++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (cyc == cut_at) return;
            adv_i  = !((cyc < 32) && hold_mask[cyc]);
            stop_i = (cyc == stop_at);
            if (stop_i) done = 1;
            else if (adv_i && !full && k == len - 1) done = 1;
            else begin
                if (adv_i) k++;
                e.col = exp_col(scol, len, full, ilv, k);
                e.last = !full && (k == len - 1);
                q.push_back(e);
            end
        end
        @(negedge clk);
        stop_i = 1'b0; adv_i = 1'b1;
        chk({tag, " R7 R9 burst over"}, 32'(col_valid_o), 0);
        chk({tag, " R11 err flag held"}, 32'(rsv_err_o), 32'(err));
    endtask

    // Monitor: scoreboard comparison after each edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && col_valid_o) begin
            if (q.size() == 0) begin
                chk("R1 unexpected beat", 32'(col_valid_o), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " col"}, 32'(col_o), 32'(e.col));
                chk({e.tag, " R7 last"}, 32'(last_o), 32'(e.last));
                chk({e.tag, " R11 err"}, 32'(rsv_err_o), 32'(e.err));
            end
        end
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset valid", 32'(col_valid_o), 0);
        chk("R12 reset last",  32'(last_o), 0);
        chk("R12 reset err",   32'(rsv_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        burst("R1 R2 seq4",           3'b010, 0, 0, 0, 8'h43, 0, -1, -1);
        burst("R2 seq8",              3'b011, 0, 0, 0, 8'h9E, 0, -1, -1);
        burst("R2 seq2",              3'b001, 0, 0, 0, 8'h11, 0, -1, -1);
        burst("R3 ilv8",              3'b011, 1, 0, 0, 8'hAD, 0, -1, -1);
        burst("R3 ilv4",              3'b010, 1, 0, 0, 8'h5E, 0, -1, -1);
        burst("R3 ilv2",              3'b001, 1, 0, 0, 8'hC1, 0, -1, -1);
        burst("R5 len1 ilv",          3'b000, 1, 0, 0, 8'h77, 0, -1, -1);
        burst("R4 page wrap",         3'b111, 0, 0, 0, 8'hFB, 0, 8, -1);
        burst("R6 single write",      3'b011, 0, 1, 1, 8'h24, 0, -1, -1);
        burst("R6 burst write",       3'b011, 0, 1, 0, 8'h24, 0, -1, -1);
        burst("R6 read ignores bit",  3'b010, 0, 0, 1, 8'h36, 0, -1, -1);
        burst("R8 stall",             3'b011, 0, 0, 0, 8'h17, 32'h0000_00A5, -1, -1);
        burst("R8 stall page",        3'b111, 0, 0, 0, 8'hFE, 32'h0000_0006, 6, -1);
        burst("R9 stop",              3'b011, 0, 0, 0, 8'h60, 0, 3, -1);
        burst("R10 first",            3'b011, 1, 0, 0, 8'h33, 0, -1, 2);
        burst("R10 second",           3'b010, 0, 0, 0, 8'h7E, 0, -1, -1);
        burst("R11 code100",          3'b100, 0, 0, 0, 8'h52, 0, -1, -1);
        burst("R11 code110",          3'b110, 1, 0, 0, 8'h53, 0, -1, -1);
        burst("R11 page ilv",         3'b111, 1, 0, 0, 8'h54, 0, -1, -1);
        burst("R11 clears",           3'b001, 0, 0, 0, 8'h55, 0, -1, -1);
        @(negedge clk);
        chk("R1 scoreboard drained", 32'(q.size()), 0);
        finish_run();
    end

endmodule